// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital core of a dual-supply processor supervisor. It receives a main-supply comparator output, a secondary-supply comparator output and a watchdog-expiry pulse. From these it produces an active-low processor reset, an active-low secondary-supply failure line, a volatile status flag, and the strobes that stop the serial command interface when the main supply sags. The asynchronous `por_n` input comes from the power-good-at-minimum detector. While it is low, every output sits at its safe value.

Reset is released only after the main supply has stayed good without a break for a hold window. That window is `HOLD_TICKS` ticks, and each tick lasts `TICK_DIV` clocks. Any dip, or a watchdog expiry, restarts the window from zero. The secondary-fail line follows its comparator with only synchronizer latency. A nonvolatile store that has already started runs to completion even when the main supply drops. New stores are refused while the supply is low.

Top module: `supply_supervisor`

## Requirements
- R1: While `por_n` is low, `reset_n_o`=0, `sec_fail_n_o`=0, `flag_o`=0, `cmd_abort_o`=0, `nv_active_o`=0 and `io_block_o`=1.
- R2: After `vmain_ok_i` rises, with `wdt_expire_i` held low, `reset_n_o` first reads 1 after exactly HOLD_TICKS*TICK_DIV+2 rising clock edges. This count includes the two synchronizer stages.
- R3: A main-supply dip seen by the synchronizer during the hold window restarts the window. Release then comes HOLD_TICKS*TICK_DIV+2 edges after the supply returns.
- R4: A one-cycle `wdt_expire_i` pulse drives `reset_n_o` low from the next edge. Reset is released HOLD_TICKS*TICK_DIV edges after that edge.
- R5: `sec_fail_n_o` follows `vsec_ok_i` two edges later in both directions, with no hold on recovery.
- R6: `flag_o` is set to 1 only by a `flag_set_i` write while the main supply is good and no watchdog pulse is present. It is cleared on a synchronized main-supply low or a watchdog pulse, and the clear wins over a simultaneous write.
- R7: After `vmain_ok_i` falls, `cmd_abort_o` is high for exactly one cycle, following the second edge. `io_block_o` is high from that same point for as long as the synchronized supply stays low.
- R8: `nv_active_o` sets on `nv_req_i` only while the synchronized main supply is good. Once set, it stays set through a supply drop until `nv_done_i`.
- R9: After `vmain_ok_i` falls, `reset_n_o` is low after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-good-at-minimum, async active-low reset |
| vmain_ok_i | input | 1 | Main-supply comparator, 1 = above trip (asynchronous) |
| vsec_ok_i | input | 1 | Secondary-supply comparator, 1 = above trip (asynchronous) |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous |
| flag_set_i | input | 1 | Register write strobe setting the status flag |
| nv_req_i | input | 1 | Request to start a nonvolatile store |
| nv_done_i | input | 1 | Nonvolatile store finished |
| reset_n_o | output | 1 | Processor reset, active low |
| sec_fail_n_o | output | 1 | Secondary-supply failure, active low |
| flag_o | output | 1 | Volatile status flag |
| cmd_abort_o | output | 1 | One-cycle abort strobe to the serial interface |
| io_block_o | output | 1 | Blocks serial reads and writes |
| nv_active_o | output | 1 | Nonvolatile store in progress |

## Verification
The hold window is exercised with a clean power-up and with a sweep that injects a one-cycle main-supply glitch at every position inside the window. A fixed release count after the last recovery separates a true restart from a counter that only pauses or ignores the dip. Watchdog pulses, and flag writes issued against low supply or together with a pulse, show whether the clear has priority. A store started before a supply drop, and a request made during one, separate "finish what is running" from "abort everything".

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int TICK_DIV   = 1000,
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic por_n,
  input  logic vmain_ok_i,
  input  logic vsec_ok_i,
  input  logic wdt_expire_i,
  input  logic flag_set_i,
  input  logic nv_req_i,
  input  logic nv_done_i,
  output logic reset_n_o,
  output logic sec_fail_n_o,
  output logic flag_o,
  output logic cmd_abort_o,
  output logic io_block_o,
  output logic nv_active_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [1:0]    main_sy, sec_sy;
  logic          main_ok, main_d;
  logic [PW-1:0] pre;
  logic [HW-1:0] hold_cnt;
  logic          restart, tick, held;

  assign main_ok = main_sy[1];
  assign restart = !main_ok || wdt_expire_i;
  assign tick    = (pre == PW'(TICK_DIV - 1));
  assign held    = (hold_cnt == HW'(HOLD_TICKS));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      main_sy <= '0;
      sec_sy  <= '0;
      main_d  <= 1'b0;
    end else begin
      main_sy <= {main_sy[0], vmain_ok_i};
      sec_sy  <= {sec_sy[0], vsec_ok_i};
      main_d  <= main_ok;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pre      <= '0;
      hold_cnt <= '0;
    end else if (restart) begin
      pre      <= '0;
      hold_cnt <= '0;
    end else if (!held) begin
      if (tick) begin
        pre      <= '0;
        hold_cnt <= hold_cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)          flag_o <= 1'b0;
    else if (restart)    flag_o <= 1'b0;
    else if (flag_set_i) flag_o <= 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                    nv_active_o <= 1'b0;
    else if (nv_done_i)            nv_active_o <= 1'b0;
    else if (nv_req_i && main_ok)  nv_active_o <= 1'b1;

  assign reset_n_o    = held;
  assign sec_fail_n_o = sec_sy[1];
  assign cmd_abort_o  = main_d && !main_ok;
  assign io_block_o   = !main_ok;
endmodule

module supply_supervisor_chk (
  input logic clk,
  input logic por_n,
  input logic main_ok,
  input logic wdt_expire_i,
  input logic nv_done_i,
  input logic reset_n_o,
  input logic flag_o,
  input logic cmd_abort_o,
  input logic nv_active_o
);
  p_release_needs_ok_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reset_n_o) |-> main_ok);
  p_wdt_forces_reset_r4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expire_i |=> !reset_n_o);
  p_low_clears_flag_r6: assert property (@(posedge clk) disable iff (!por_n)
    !main_ok |=> !flag_o);
  p_abort_single_r7: assert property (@(posedge clk) disable iff (!por_n)
    cmd_abort_o |=> !cmd_abort_o);
  p_store_survives_r8: assert property (@(posedge clk) disable iff (!por_n)
    (nv_active_o && !nv_done_i) |=> nv_active_o);
  p_drop_resets_r9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(main_ok) |=> !reset_n_o);
endmodule

bind supply_supervisor supply_supervisor_chk u_chk (
  .clk(clk), .por_n(por_n), .main_ok(main_ok), .wdt_expire_i(wdt_expire_i),
  .nv_done_i(nv_done_i), .reset_n_o(reset_n_o), .flag_o(flag_o),
  .cmd_abort_o(cmd_abort_o), .nv_active_o(nv_active_o)
);

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb;
  localparam int DIV  = 3;
  localparam int HOLD = 4;
  localparam int T    = DIV * HOLD;

  logic clk = 1'b0;
  logic por_n = 1'b0, vmain = 1'b0, vsec = 1'b0, wdt = 1'b0;
  logic fset = 1'b0, nvreq = 1'b0, nvdone = 1'b0;
  logic rst_n, sfail_n, flag, abort, blk, nvact;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .por_n(por_n), .vmain_ok_i(vmain), .vsec_ok_i(vsec),
    .wdt_expire_i(wdt), .flag_set_i(fset), .nv_req_i(nvreq), .nv_done_i(nvdone),
    .reset_n_o(rst_n), .sec_fail_n_o(sfail_n), .flag_o(flag),
    .cmd_abort_o(abort), .io_block_o(blk), .nv_active_o(nvact));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges_to_release(output int n);
    n = 0;
    for (int i = 1; i <= 4 * T; i++) begin
      step(1);
      if (rst_n === 1'b1) begin n = i; break; end
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    summary();
  end

  initial begin
    int n;
    step(3);
    // R1 reset state
    chk("R1 reset_n", rst_n, 0); chk("R1 sec_fail_n", sfail_n, 0);
    chk("R1 flag", flag, 0);     chk("R1 abort", abort, 0);
    chk("R1 nv_active", nvact, 0); chk("R1 io_block", blk, 1);
    por_n = 1'b1;
    // R5 secondary rises with two-edge latency, no hold
    vsec = 1'b1;
    step(1); chk("R5 sec after 1 edge", sfail_n, 0);
    step(1); chk("R5 sec after 2 edges", sfail_n, 1);
    // R2 power-up release count
    vmain = 1'b1;
    edges_to_release(n); chk("R2 release edges", n, T + 2);
    // R6 flag write
    fset = 1'b1; step(1); fset = 1'b0;
    chk("R6 flag set by write", flag, 1);
    // R7 / R9 / R6 on a supply drop
    vmain = 1'b0;
    step(1); chk("R7 abort not yet", abort, 0); chk("R9 still released", rst_n, 1);
    step(1); chk("R7 abort pulse", abort, 1); chk("R7 io_block", blk, 1);
    step(1); chk("R7 abort one cycle", abort, 0); chk("R9 reset low", rst_n, 0);
    chk("R6 flag cleared by drop", flag, 0);
    // R6 write ignored while low
    fset = 1'b1; step(1); fset = 1'b0; step(1);
    chk("R6 write ignored when low", flag, 0);
    // R3 glitch sweep across the hold window
    for (int d = 1; d <= T - 2; d++) begin
      vmain = 1'b0; step(4);
      vmain = 1'b1; step(d);
      chk("R3 no early release", rst_n, 0);
      vmain = 1'b0; step(1); vmain = 1'b1;
      edges_to_release(n); chk($sformatf("R3 restart at offset %0d", d), n, T + 2);
    end
    // R4 watchdog pulse, also clears flag; clear wins over write
    fset = 1'b1; step(1); fset = 1'b0;
    chk("R6 flag set again", flag, 1);
    wdt = 1'b1; fset = 1'b1; step(1); wdt = 1'b0; fset = 1'b0;
    chk("R4 reset after pulse", rst_n, 0); chk("R6 clear wins", flag, 0);
    edges_to_release(n); chk("R4 hold after pulse", n, T);
    // R8 store survives a drop
    nvreq = 1'b1; step(1); nvreq = 1'b0;
    chk("R8 store started", nvact, 1);
    vmain = 1'b0; step(5);
    chk("R8 store survives drop", nvact, 1); chk("R7 io_block held", blk, 1);
    nvdone = 1'b1; step(1); nvdone = 1'b0;
    chk("R8 store done", nvact, 0);
    nvreq = 1'b1; step(1); nvreq = 1'b0; step(1);
    chk("R8 request refused when low", nvact, 0);
    vmain = 1'b1; step(3);
    chk("R7 io_block released", blk, 0);
    // R5 secondary drop and immediate recovery
    vsec = 1'b0;
    step(1); chk("R5 sec fall 1 edge", sfail_n, 1);
    step(1); chk("R5 sec fall 2 edges", sfail_n, 0);
    vsec = 1'b1; step(2); chk("R5 sec recover no hold", sfail_n, 1);
    summary();
  end
endmodule